// File: doc/BRIEF.md
# Packed Two-Word Bitonic Merge Unit

This unit takes two W-bit words, each carrying K unsigned keys of W/K bits packed into equal fields. The first operand word holds its keys in non-decreasing order from left (most significant field) to right; the second holds them in non-increasing order. Joined end to end, the two words form one bitonic run of 2K keys. The unit splits that run into two result words. The high word holds the K largest keys and the low word holds the K smallest.

Each result word has its own direction control. A caller that chains merges can set the key order of each result so that the result feeds the next merge without a field-reversal step. Inside, a half-cleaner takes the fieldwise maximum and minimum of the two operands. Each half then passes through log2(K) compare-exchange stages. One output register stage sits behind this logic. Valid/ready handshakes are used on both sides.

Top module: `packed_word_merge`

## Requirements
- R1: After reset, out_valid_o is low and in_ready_o is high.
- R2: For every accepted pair, the keys of hi_o and lo_o together form the same multiset as the 2K keys of a_i and b_i. hi_o holds the K largest of them and lo_o the K smallest. Key p (p = 0 is leftmost) occupies bits [W-1-p*W/K -: W/K].
- R3: Every key in hi_o is greater than or equal to every key in lo_o.
- R4: hi_desc_i = 1 orders hi_o non-increasing from left to right. hi_desc_i = 0 orders it non-decreasing.
- R5: lo_desc_i = 1 orders lo_o non-increasing from left to right. lo_desc_i = 0 orders it non-decreasing.
- R6: Keys are unsigned and use the full field width, so the values 0 and 2^(W/K)-1 merge correctly.
- R7: A pair accepted on a clock edge (in_valid_i and in_ready_o both high) appears on hi_o/lo_o with out_valid_o high after that edge.
- R8: While out_valid_o is high and out_ready_i is low, in_ready_o is low, and out_valid_o, hi_o and lo_o hold their values.
- R9: With out_ready_i held high, the unit accepts one pair on every clock.
- R10: The direction bits are sampled with the accepted pair. Changing them while a result waits does not alter that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair is valid |
| in_ready_o | output | 1 | Unit can take a pair |
| a_i | input | W | Keys in non-decreasing order, left to right |
| b_i | input | W | Keys in non-increasing order, left to right |
| hi_desc_i | input | 1 | Key order of the high result (1 = non-increasing) |
| lo_desc_i | input | 1 | Key order of the low result (1 = non-increasing) |
| out_valid_o | output | 1 | Result is valid |
| out_ready_i | input | 1 | Consumer takes the result |
| hi_o | output | W | K largest keys |
| lo_o | output | W | K smallest keys |

## Verification
Random sorted operands exercise the general split. Operands where every key of one word exceeds every key of the other separate a correct half-cleaner from one that swaps the wrong way. Runs of equal keys, and words filled with 0 and the maximum field value, expose signed comparisons and ties in the compare-exchange stages. All four direction combinations are applied under random backpressure. The direction inputs are also toggled during stalls, which separates sampling the direction at accept time from using it live.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    ORD_ASC  = 1'b0,
    ORD_DESC = 1'b1
  } ord_e;
endpackage

// File: rtl/pwm_half_clean.sv
module pwm_half_clean #(
  parameter int W = 32,
  parameter int K = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int F = W / K;

  for (genvar p = 0; p < K; p++) begin : g_fld
    logic [F-1:0] ka, kb;
    assign ka = a_i[W-1-p*F -: F];
    assign kb = b_i[W-1-p*F -: F];
    assign hi_o[W-1-p*F -: F] = (ka >= kb) ? ka : kb;
    assign lo_o[W-1-p*F -: F] = (ka >= kb) ? kb : ka;
  end
endmodule

// File: rtl/pwm_bitonic_net.sv
module pwm_bitonic_net
  import pwm_pkg::*;
#(
  parameter int W = 32,
  parameter int K = 4
) (
  input  logic [W-1:0] data_i,
  input  ord_e         ord_i,
  output logic [W-1:0] data_o
);
  localparam int F = W / K;
  localparam int S = $clog2(K);

  logic [W-1:0] stg [S+1];
  assign stg[0] = data_i;

  for (genvar s = 0; s < S; s++) begin : g_stage
    localparam int D = K >> (s + 1);
    for (genvar p = 0; p < K; p++) begin : g_pair
      if (((p / D) % 2) == 0) begin : g_cx
        logic [F-1:0] x, y;
        logic         swap;
        assign x = stg[s][W-1-p*F -: F];
        assign y = stg[s][W-1-(p+D)*F -: F];
        // descending: larger key on the left
        assign swap = (ord_i == ORD_DESC) ? (x < y) : (x > y);
        assign stg[s+1][W-1-p*F -: F]     = swap ? y : x;
        assign stg[s+1][W-1-(p+D)*F -: F] = swap ? x : y;
      end
    end
  end

  assign data_o = stg[S];
endmodule

// File: rtl/packed_word_merge.sv
module packed_word_merge
  import pwm_pkg::*;
#(
  parameter int W = 32,
  parameter int K = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         hi_desc_i,
  input  logic         lo_desc_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int F = W / K;

  logic [W-1:0] hc_hi, hc_lo, srt_hi, srt_lo;
  logic [W-1:0] hi_q, lo_q;
  logic         vld_q;
  logic         fire_in;

  pwm_half_clean #(.W(W), .K(K)) u_hc (
    .a_i (a_i),
    .b_i (b_i),
    .hi_o(hc_hi),
    .lo_o(hc_lo)
  );

  pwm_bitonic_net #(.W(W), .K(K)) u_net_hi (
    .data_i(hc_hi),
    .ord_i (ord_e'(hi_desc_i)),
    .data_o(srt_hi)
  );

  pwm_bitonic_net #(.W(W), .K(K)) u_net_lo (
    .data_i(hc_lo),
    .ord_i (ord_e'(lo_desc_i)),
    .data_o(srt_lo)
  );

  assign in_ready_o = !vld_q || out_ready_i;
  assign fire_in    = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (fire_in) begin
      vld_q <= 1'b1;
      hi_q  <= srt_hi;
      lo_q  <= srt_lo;
    end else if (out_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid_o = vld_q;
  assign hi_o        = hi_q;
  assign lo_o        = lo_q;

  // checking helpers
  function automatic logic in_order(input logic [W-1:0] w, input logic desc);
    logic ok;
    ok = 1'b1;
    for (int p = 0; p < K - 1; p++) begin
      if (desc  && (w[W-1-p*F -: F] < w[W-1-(p+1)*F -: F])) ok = 1'b0;
      if (!desc && (w[W-1-p*F -: F] > w[W-1-(p+1)*F -: F])) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic split_ok(input logic [W-1:0] h, input logic [W-1:0] l);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < K; i++)
      for (int j = 0; j < K; j++)
        if (h[W-1-i*F -: F] < l[W-1-j*F -: F]) ok = 1'b0;
    return ok;
  endfunction

  p_split_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> split_ok(hi_o, lo_o));

  p_hi_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> in_order(hi_o, $past(hi_desc_i)));

  p_lo_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> in_order(lo_o, $past(lo_desc_i)));

  p_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  p_stall_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(hi_o) && $stable(lo_o)));

  p_drain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ready_i |-> in_ready_o);
endmodule

// File: tb/packed_word_merge_bench.sv
module packed_word_merge_bench;
  localparam int W = 32;
  localparam int K = 4;
  localparam int F = W / K;
  localparam int KMAX = (1 << F) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, out_ready = 1'b0;
  logic         hi_desc = 1'b0, lo_desc = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         in_ready, out_valid;
  logic [W-1:0] hi, lo;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  packed_word_merge #(.W(W), .K(K)) u_packed_word_merge (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .a_i(a), .b_i(b), .hi_desc_i(hi_desc), .lo_desc_i(lo_desc),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .hi_o(hi), .lo_o(lo)
  );

  // model state
  logic         m_vld = 1'b0;
  logic [W-1:0] m_hi = '0, m_lo = '0;
  int           pat = 0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pat=%0d act=%h exp=%h", req, pat, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pack(input int k [K]);
    logic [W-1:0] w;
    w = '0;
    for (int p = 0; p < K; p++) w[W-1-p*F -: F] = k[p][F-1:0];
    return w;
  endfunction

  // expected result from the requirements: sort all 2K keys, split, order
  task automatic reference(input logic [W-1:0] ia, input logic [W-1:0] ib,
                           input logic hd, input logic ld,
                           output logic [W-1:0] eh, output logic [W-1:0] el);
    int all [2*K];
    int h [K], l [K];
    for (int p = 0; p < K; p++) begin
      all[p]     = int'(ia[W-1-p*F -: F]);
      all[p + K] = int'(ib[W-1-p*F -: F]);
    end
    for (int i = 0; i < 2*K; i++)
      for (int j = 0; j < 2*K - 1 - i; j++)
        if (all[j] > all[j+1]) begin
          int t; t = all[j]; all[j] = all[j+1]; all[j+1] = t;
        end
    for (int p = 0; p < K; p++) begin
      h[p] = hd ? all[2*K-1-p] : all[K+p];
      l[p] = ld ? all[K-1-p]   : all[p];
    end
    eh = pack(h);
    el = pack(l);
  endtask

  // build a legal operand pair for a given pattern
  task automatic make_pair(input int kind, output logic [W-1:0] oa, output logic [W-1:0] ob);
    int x [K], y [K];
    for (int p = 0; p < K; p++) begin
      case (kind)
        0: begin x[p] = int'($urandom_range(KMAX)); y[p] = int'($urandom_range(KMAX)); end
        1: begin x[p] = 77; y[p] = 77; end
        2: begin x[p] = KMAX; y[p] = 0; end
        3: begin x[p] = int'($urandom_range(KMAX, 200)); y[p] = int'($urandom_range(50)); end
        4: begin x[p] = int'($urandom_range(50)); y[p] = int'($urandom_range(KMAX, 200)); end
        5: begin x[p] = (p % 2 == 0) ? 0 : KMAX; y[p] = (p % 2 == 0) ? KMAX : 0; end
        default: begin x[p] = int'($urandom_range(3)); y[p] = int'($urandom_range(3)); end
      endcase
    end
    for (int i = 0; i < K; i++)
      for (int j = 0; j < K - 1 - i; j++) begin
        if (x[j] > x[j+1]) begin int t; t = x[j]; x[j] = x[j+1]; x[j+1] = t; end
        if (y[j] < y[j+1]) begin int t; t = y[j]; y[j] = y[j+1]; y[j+1] = t; end
      end
    oa = pack(x);
    ob = pack(y);
  endtask

  // compare outputs against the model, just before the next rising edge
  task automatic step(input string tag);
    logic [W-1:0] eh, el;
    #4;
    chk("R7/R8 out_valid", {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, m_vld});
    chk("R8/R9 in_ready", {{(W-1){1'b0}}, in_ready}, {{(W-1){1'b0}}, (!m_vld || out_ready)});
    if (m_vld) begin
      chk({"R2/R4 hi ", tag}, hi, m_hi);
      chk({"R2/R5 lo ", tag}, lo, m_lo);
    end
    if (in_valid && (!m_vld || out_ready)) begin
      reference(a, b, hi_desc, lo_desc, eh, el);
      m_vld = 1'b1; m_hi = eh; m_lo = el;
    end else if (out_ready) begin
      m_vld = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] ta, tb;
    @(negedge clk);
    #2;
    chk("R1 out_valid", {{(W-1){1'b0}}, out_valid}, '0);
    chk("R1 in_ready", {{(W-1){1'b0}}, in_ready}, {{(W-1){1'b0}}, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);

    // directed: every pattern under every direction pair, no backpressure (R9)
    for (int kind = 0; kind < 7; kind++) begin
      for (int d = 0; d < 4; d++) begin
        pat = kind;
        make_pair(kind, ta, tb);
        a = ta; b = tb; hi_desc = d[1]; lo_desc = d[0];
        in_valid = 1'b1; out_ready = 1'b1;
        step((kind == 2 || kind == 5) ? "R6 extremes" : "R3 split");
      end
    end

    // R10: stall with a result held, toggle direction bits, then release
    pat = 10;
    make_pair(0, ta, tb);
    a = ta; b = tb; hi_desc = 1'b1; lo_desc = 1'b0; in_valid = 1'b1; out_ready = 1'b0;
    step("R10 capture");
    in_valid = 1'b0;
    hi_desc = 1'b0; lo_desc = 1'b1;
    for (int i = 0; i < 3; i++) step("R10 held");
    out_ready = 1'b1;
    step("R10 release");

    // random traffic with backpressure
    for (int n = 0; n < 400; n++) begin
      pat = 100 + (n % 7);
      make_pair(n % 7, ta, tb);
      a = ta; b = tb;
      hi_desc = 1'($urandom_range(1));
      lo_desc = 1'($urandom_range(1));
      in_valid = ($urandom_range(3) != 0);
      out_ready = ($urandom_range(2) != 0);
      step("R2 random");
    end
    in_valid = 1'b0; out_ready = 1'b1;
    step("drain");
    step("idle");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule